// File: doc/BRIEF.md
# Configurable Synchronous Serial Receiver

This block receives digitized radio samples from a three-wire serial link: a bit clock, a sync line and a data line. All three are asynchronous to the system clock. They pass through synchronizers, and the block then finds both edges of the bit clock in the system-clock domain. Data is sampled only on bit-clock rising edges. Both delays are counted in half bit-clock periods, so they use both edges. Words of a programmable length, 8 to 32 bits, are assembled from the sampled bits and presented right-justified on a one-cycle valid strobe, together with a channel tag.

Two framing schemes are available. In left/right mode, every change of the sync level starts a word, and the tag tells which half of the frame the word belongs to. In frame-start pulse mode, a one-bit-wide active pulse starts each word. Static configuration inputs set the following:
- the framing mode;
- the sync polarity;
- the bit order;
- the delay from the sync event to the first data bit;
- the minimum gap from the last data bit to the next sync event;
- the word length.

A sync event that arrives too early sets a sticky framing-error flag. An illegal gap setting raises a configuration-error output.

The control state machine has five states:
- **ARM**: after reset, waits for the first bit-clock rising edge and only records the sync level there.
- **IDLE**: waits for a sync event.
- **DELAY**: counts the data delay.
- **SHIFT**: samples one bit on each rising edge.
- **GUARD**: counts the sync delay after the last bit.

The transitions are:
- **ARM→IDLE**: on the first rising edge.
- **any armed state→DELAY**: on a sync event when the data delay is non-zero.
- **any armed state→SHIFT**: on a sync event when the data delay is zero. The first bit is taken on that same edge.
- **DELAY→SHIFT**: when the data delay has elapsed at a rising edge.
- **SHIFT→GUARD**: when the final bit is sampled.
- **GUARD→IDLE**: when the sync delay has elapsed at a bit-clock edge.

Top module: `sync_serial_rx`

## Requirements
- R1: Left/right mode (`cfg_lr_mode`=1) starts a word on every change of the sync level seen at a bit-clock rising edge. `word_chan` is 1 when the new level equals the active level and 0 when it is the inactive level.
- R2: Pulse mode (`cfg_lr_mode`=0) starts a word only when sync goes from inactive to active at a rising edge. In this mode `word_chan` is always 1.
- R3: `cfg_sync_pol`=1 makes high the active sync level. `cfg_sync_pol`=0 makes low the active sync level.
- R4: With `cfg_lsb_first`=1, the n-th received bit goes to bit n of the word. With `cfg_lsb_first`=0, the first received bit is the word's most significant bit. In both orders the word is right-justified in `word_data`, and the bits above the word length are 0.
- R5: With a data delay of D half periods (D from 0 to 4), the first data bit is sampled at the rising edge that comes ceil(D/2) bit-clock periods after the sync-event edge. D=0 means the event edge itself.
- R6: With a sync delay of S half periods, a sync event m periods after the last bit's rising edge is accepted when 2m ≥ S. An event that comes earlier sets `frame_err`. The word already received is still output, and the new word is still started.
- R7: Sync-delay codes 5 and 7 behave as 0 and drive `cfg_err` high. Codes 0, 1, 2, 3, 4 and 6 keep `cfg_err` low.
- R8: A sync event during DELAY or SHIFT discards the partial word, sets `frame_err`, and starts a new word from that event.
- R9: `frame_err` stays set until `err_clear` is high. When a set and a clear fall in the same cycle, the set wins.
- R10: `word_valid` is high for exactly one system-clock cycle after the final bit of a word is sampled. `word_data` and `word_chan` only change in that cycle.
- R11: `cfg_word_len` below 8 acts as 8, and `cfg_word_len` above 32 acts as 32.
- R12: The first rising edge after reset only records the sync level and never counts as a sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| sync_in | input | 1 | Serial sync line (asynchronous) |
| sdata_in | input | 1 | Serial data line (asynchronous) |
| cfg_lr_mode | input | 1 | 1 = left/right framing, 0 = frame-start pulse framing |
| cfg_sync_pol | input | 1 | Active level of sync: 1 = high, 0 = low |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| cfg_data_dly | input | 3 | Sync event to first bit, in half bit-clock periods (0..4) |
| cfg_sync_dly | input | 3 | Last bit to next sync event, in half periods (0,1,2,3,4,6) |
| cfg_word_len | input | 6 | Word length in bits (8..32) |
| err_clear | input | 1 | Clears the framing-error flag |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Completed word, right-justified |
| word_chan | output | 1 | Channel tag of the completed word |
| frame_err | output | 1 | Sticky framing-error flag |
| cfg_err | output | 1 | Illegal sync-delay code is programmed |

## Verification
The following are checked on every cycle by the assertions:
- the strobe lasts a single cycle;
- the output word changes only with its strobe;
- no bit above the programmed length is ever set;
- the framing-error flag holds until it is cleared.

The other behaviours can only be shown by the bench's scenarios:
- word content under each combination of mode, polarity and bit order;
- the placement of the first bit for every data delay;
- the acceptance boundary of each sync delay;
- discarding a partial word on an early event;
- the arming behaviour after reset.

In those scenarios, every received word is compared against the word the bench transmitted.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_IDLE,
        ST_DELAY,
        ST_SHIFT,
        ST_GUARD
    } rx_state_t;

    localparam int HALF_W   = 3;
    localparam int HALF_MAX = (1 << HALF_W) - 1;

endpackage

// File: rtl/ssrx_edge_sync.sv
module ssrx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic sync_in,
    input  logic sdata_in,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic sync_lvl,
    output logic data_lvl
);

    // bit 2: bit clock, bit 1: sync, bit 0: data
    logic [2:0] stage_q [STAGES];
    logic       bclk_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 3'b000;
                else        stage_q[g] <= {bclk_in, sync_in, sdata_in};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 3'b000;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= stage_q[STAGES-1][2];
    end

    assign bclk_rise = stage_q[STAGES-1][2] & ~bclk_d;
    assign bclk_fall = ~stage_q[STAGES-1][2] & bclk_d;
    assign sync_lvl  = stage_q[STAGES-1][1];
    assign data_lvl  = stage_q[STAGES-1][0];

endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
    import ssrx_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 8,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             sync_lvl,
    input  logic             cfg_lr_mode,
    input  logic             cfg_sync_pol,
    input  logic [2:0]       cfg_data_dly,
    input  logic [2:0]       cfg_sync_dly,
    input  logic [CNT_W-1:0] cfg_word_len,
    input  logic             err_clear,
    output logic             bit_cap,
    output logic             word_clr,
    output logic             word_done,
    output logic [CNT_W-1:0] bit_idx,
    output logic             chan_tag,
    output logic             ferr_set,
    output logic             frame_err,
    output logic             cfg_err
);

    localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(MAX_LEN);

    rx_state_t           st_q, st_n;
    logic [HALF_W-1:0]   half_cnt;
    logic [HALF_W:0]     half_p1;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CNT_W-1:0]    len_eff;
    logic [2:0]          sdly_eff;
    logic                prev_sync;
    logic                armed;
    logic                sync_ev;
    logic                early;
    logic                any_edge;
    logic                ferr_q;
    logic                chan_q;

    // configuration conditioning
    always_comb begin
        if (cfg_word_len < LEN_LO)      len_eff = LEN_LO;
        else if (cfg_word_len > LEN_HI) len_eff = LEN_HI;
        else                            len_eff = cfg_word_len;
    end

    always_comb begin
        cfg_err  = 1'b0;
        sdly_eff = cfg_sync_dly;
        if (cfg_sync_dly == 3'd5 || cfg_sync_dly == 3'd7) begin
            cfg_err  = 1'b1;
            sdly_eff = 3'd0;
        end
    end

    // sync event detection at rising bit-clock edges
    assign armed    = (st_q != ST_ARM);
    assign any_edge = bclk_rise | bclk_fall;
    assign half_p1  = {1'b0, half_cnt} + 1'b1;

    always_comb begin
        if (cfg_lr_mode)
            sync_ev = bclk_rise & armed & (sync_lvl != prev_sync);
        else
            sync_ev = bclk_rise & armed & (sync_lvl == cfg_sync_pol)
                      & (prev_sync != cfg_sync_pol);
    end

    always_comb begin
        unique case (st_q)
            ST_DELAY, ST_SHIFT: early = 1'b1;
            ST_GUARD:           early = (half_p1 < {1'b0, sdly_eff});
            default:            early = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ARM;
        else        st_q <= st_n;
    end

    // next state and control outputs
    always_comb begin
        st_n      = st_q;
        bit_cap   = 1'b0;
        word_clr  = 1'b0;
        word_done = 1'b0;
        ferr_set  = 1'b0;
        unique case (st_q)
            ST_ARM: begin
                if (bclk_rise) st_n = ST_IDLE;
            end
            ST_IDLE, ST_DELAY, ST_SHIFT, ST_GUARD: begin
                if (sync_ev) begin
                    ferr_set = early;
                    word_clr = 1'b1;
                    if (cfg_data_dly == 3'd0) begin
                        bit_cap = 1'b1;
                        st_n    = ST_SHIFT;
                    end else begin
                        st_n    = ST_DELAY;
                    end
                end else begin
                    unique case (st_q)
                        ST_DELAY: begin
                            if (bclk_rise && half_p1 >= {1'b0, cfg_data_dly}) begin
                                bit_cap = 1'b1;
                                st_n    = ST_SHIFT;
                            end
                        end
                        ST_SHIFT: begin
                            if (bclk_rise) begin
                                bit_cap = 1'b1;
                                if (bit_cnt + 1'b1 == len_eff) begin
                                    word_done = 1'b1;
                                    st_n      = ST_GUARD;
                                end
                            end
                        end
                        ST_GUARD: begin
                            if (any_edge && half_p1 >= {1'b0, sdly_eff})
                                st_n = ST_IDLE;
                        end
                        default: st_n = st_q;
                    endcase
                end
            end
            default: st_n = ST_ARM;
        endcase
    end

    // counters and captured state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt  <= '0;
            bit_cnt   <= '0;
            prev_sync <= 1'b0;
            chan_q    <= 1'b0;
            ferr_q    <= 1'b0;
        end else begin
            if (sync_ev || word_done)
                half_cnt <= '0;
            else if (any_edge && half_cnt != HALF_W'(HALF_MAX))
                half_cnt <= half_cnt + 1'b1;

            if (word_clr)
                bit_cnt <= bit_cap ? CNT_W'(1) : '0;
            else if (bit_cap)
                bit_cnt <= bit_cnt + 1'b1;

            if (bclk_rise)
                prev_sync <= sync_lvl;

            if (sync_ev)
                chan_q <= (sync_lvl == cfg_sync_pol);

            if (ferr_set)
                ferr_q <= 1'b1;
            else if (err_clear)
                ferr_q <= 1'b0;
        end
    end

    assign bit_idx   = word_clr ? '0 : bit_cnt;
    assign chan_tag  = chan_q;
    assign frame_err = ferr_q;

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
    parameter int MAX_LEN = 32,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_clr,
    input  logic               bit_cap,
    input  logic               word_done,
    input  logic               bit_in,
    input  logic [CNT_W-1:0]   bit_idx,
    input  logic               lsb_first,
    input  logic               chan_in,
    output logic               word_valid,
    output logic [MAX_LEN-1:0] word_data,
    output logic               word_chan
);

    logic [MAX_LEN-1:0] acc_q;
    logic [MAX_LEN-1:0] base;
    logic [MAX_LEN-1:0] acc_n;

    always_comb begin
        base  = word_clr ? '0 : acc_q;
        acc_n = base;
        if (bit_cap) begin
            if (lsb_first) begin
                for (int i = 0; i < MAX_LEN; i++)
                    if (bit_idx == CNT_W'(i)) acc_n[i] = bit_in;
            end else begin
                acc_n = {base[MAX_LEN-2:0], bit_in};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_chan  <= 1'b0;
        end else begin
            if (word_clr || bit_cap)
                acc_q <= acc_n;
            word_valid <= word_done;
            if (word_done) begin
                word_data <= acc_n;
                word_chan <= chan_in;
            end
        end
    end

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
    parameter int MAX_LEN     = 32,
    parameter int MIN_LEN     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bclk_in,
    input  logic               sync_in,
    input  logic               sdata_in,
    input  logic               cfg_lr_mode,
    input  logic               cfg_sync_pol,
    input  logic               cfg_lsb_first,
    input  logic [2:0]         cfg_data_dly,
    input  logic [2:0]         cfg_sync_dly,
    input  logic [CNT_W-1:0]   cfg_word_len,
    input  logic               err_clear,
    output logic               word_valid,
    output logic [MAX_LEN-1:0] word_data,
    output logic               word_chan,
    output logic               frame_err,
    output logic               cfg_err
);

    logic             bclk_rise;
    logic             bclk_fall;
    logic             sync_lvl;
    logic             data_lvl;
    logic             bit_cap;
    logic             word_clr;
    logic             word_done;
    logic [CNT_W-1:0] bit_idx;
    logic             chan_tag;
    logic             ferr_set;

    ssrx_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_in   (bclk_in),
        .sync_in   (sync_in),
        .sdata_in  (sdata_in),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .sync_lvl  (sync_lvl),
        .data_lvl  (data_lvl)
    );

    ssrx_ctrl #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_rise    (bclk_rise),
        .bclk_fall    (bclk_fall),
        .sync_lvl     (sync_lvl),
        .cfg_lr_mode  (cfg_lr_mode),
        .cfg_sync_pol (cfg_sync_pol),
        .cfg_data_dly (cfg_data_dly),
        .cfg_sync_dly (cfg_sync_dly),
        .cfg_word_len (cfg_word_len),
        .err_clear    (err_clear),
        .bit_cap      (bit_cap),
        .word_clr     (word_clr),
        .word_done    (word_done),
        .bit_idx      (bit_idx),
        .chan_tag     (chan_tag),
        .ferr_set     (ferr_set),
        .frame_err    (frame_err),
        .cfg_err      (cfg_err)
    );

    ssrx_shift #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_clr   (word_clr),
        .bit_cap    (bit_cap),
        .word_done  (word_done),
        .bit_in     (data_lvl),
        .bit_idx    (bit_idx),
        .lsb_first  (cfg_lsb_first),
        .chan_in    (chan_tag),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_chan  (word_chan)
    );

endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk #(
    parameter int MAX_LEN = 32,
    parameter int MIN_LEN = 8,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cfg_word_len,
    input logic               err_clear,
    input logic               word_valid,
    input logic [MAX_LEN-1:0] word_data,
    input logic               frame_err,
    input logic               ferr_set
);

    int                 len_int;
    logic [MAX_LEN-1:0] hi_mask;

    always_comb begin
        len_int = int'(cfg_word_len);
        if (len_int < MIN_LEN) len_int = MIN_LEN;
        if (len_int > MAX_LEN) len_int = MAX_LEN;
        for (int i = 0; i < MAX_LEN; i++)
            hi_mask[i] = (i >= len_int);
    end

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_data) |-> word_valid);

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((word_data & hi_mask) == '0));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !ferr_set) |=> !frame_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clear) |=> frame_err);

endmodule

bind sync_serial_rx sync_serial_rx_chk #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word_len (cfg_word_len),
    .err_clear    (err_clear),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .frame_err    (frame_err),
    .ferr_set     (ferr_set)
);

// File: tb/sync_serial_rx_bench.sv
`timescale 1ns/1ps
module sync_serial_rx_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0, sync_in = 1'b0, sdata_in = 1'b0;
    logic        lr = 1'b1, pol = 1'b1, lsb = 1'b0;
    logic [2:0]  dd = 3'd2, sd = 3'd0;
    logic [5:0]  wlen = 6'd16;
    logic        err_clear = 1'b0;
    logic        word_valid, word_chan, frame_err, cfg_err;
    logic [31:0] word_data;

    int          checks = 0, errors = 0, cyc = 0;
    logic [32:0] exp_q[$];
    string       cur_req = "R1";
    logic [31:0] seed = 32'h1234_5678;
    logic        hold_lvl = 1'b0;

    always #2.5 clk = ~clk;

    sync_serial_rx u_sync_serial_rx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .sync_in(sync_in),
        .sdata_in(sdata_in), .cfg_lr_mode(lr), .cfg_sync_pol(pol),
        .cfg_lsb_first(lsb), .cfg_data_dly(dd), .cfg_sync_dly(sd),
        .cfg_word_len(wlen), .err_clear(err_clear), .word_valid(word_valid),
        .word_data(word_data), .word_chan(word_chan), .frame_err(frame_err),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s: unexpected word actual %h expected none", cur_req, word_data);
            end else begin
                chk(cur_req, {31'd0, word_chan, word_data}, {31'd0, exp_q.pop_front()});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int len_eff();
        return (wlen < 8) ? 8 : (wlen > 32) ? 32 : int'(wlen);
    endfunction

    function automatic int sd_eff();
        return (sd == 3'd5 || sd == 3'd7) ? 0 : int'(sd);
    endfunction

    function automatic logic [31:0] next_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ {seed[15:0], seed[31:16]};
    endfunction

    // one bit-clock period; sync and data set while the clock is low
    task automatic bper(input logic s, input logic d);
        @(negedge clk);
        sync_in  = s;
        sdata_in = d;
        repeat (HALF) @(negedge clk);
        bclk_in = 1'b1;
        repeat (HALF) @(negedge clk);
        bclk_in = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk_in = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one word: event edge, ceil(D/2) edges of delay, bits, then the gap
    task automatic send_word(input logic [31:0] v, input logic ch, input int nbits,
                             input int gap, input logic push);
        int    len = len_eff();
        int    k   = (int'(dd) + 1) / 2;
        int    m   = (gap > 0) ? gap : ((sd_eff() == 0) ? 1 : (sd_eff() + 1) / 2);
        logic  ev  = lr ? (ch ? pol : ~pol) : pol;
        logic [31:0] vm = (len == 32) ? v : (v & ((32'd1 << len) - 1));
        hold_lvl = lr ? ev : ~pol;
        if (push) exp_q.push_back({lr ? ch : 1'b1, vm});
        for (int r = 0; r < k + nbits; r++) begin
            int  j = r - k;
            logic b = 1'b0;
            if (j >= 0) b = lsb ? vm[j] : vm[len - 1 - j];
            bper((r == 0) ? ev : hold_lvl, b);
        end
        if (push) for (int r = 1; r < m; r++) bper(hold_lvl, 1'b0);
    endtask

    task automatic preamble();
        hold_lvl = ~pol;
        for (int i = 0; i < 3; i++) bper(~pol, 1'b0);
    endtask

    task automatic finish_scn(input string req);
        for (int i = 0; i < 3; i++) bper(hold_lvl, 1'b0);
        repeat (10) @(negedge clk);
        chk(req, exp_q.size(), 0);
    endtask

    task automatic run_std(input int nw, input string req);
        cur_req = req;
        do_reset();
        preamble();
        for (int w = 0; w < nw; w++) send_word(next_val(), (w % 2) == 0, len_eff(), 0, 1'b1);
        finish_scn(req);
        // R6/R12: legal gaps and the arming edge leave no framing error
        chk({req, "/R6/R12 frame_err"}, frame_err, 0);
    endtask

    initial begin
        logic [2:0] legal_sd [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
        do_reset();
        chk("R10 reset valid", word_valid, 0);
        chk("R9 reset frame_err", frame_err, 0);
        chk("R10 reset data", word_data, 0);

        // R1/R2/R3/R4/R5: modes, polarities, bit orders, every data delay
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 5; d++) begin
                lr = c[0]; pol = c[1]; lsb = c[2];
                dd = 3'(d); sd = legal_sd[(c + d) % 6];
                wlen = 6'(8 + ((c * 5 + d * 7) % 25));
                run_std(3, lr ? "R1/R3/R4/R5" : "R2/R3/R4/R5");
            end
        end

        // R6/R7: every sync-delay code in both modes, at the minimum legal gap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 8; s++) begin
                lr = md[0]; pol = 1'b1; lsb = 1'b0; dd = 3'd2; sd = 3'(s); wlen = 6'd8;
                run_std(3, "R6");
                chk("R7 cfg_err", cfg_err, (s == 5 || s == 7) ? 1 : 0);
            end
        end

        // R6: event one period after the last bit with a delay of 6 half periods
        lr = 1'b1; pol = 1'b0; lsb = 1'b1; dd = 3'd1; sd = 3'd6; wlen = 6'd12;
        cur_req = "R6";
        do_reset(); preamble();
        send_word(next_val(), 1'b1, 12, 1, 1'b1);
        send_word(next_val(), 1'b0, 12, 0, 1'b1);
        finish_scn("R6 early gap words");
        chk("R6 early gap frame_err", frame_err, 1);

        // R8/R9: early event during SHIFT discards the partial word, both modes
        for (int md = 0; md < 2; md++) begin
            lr = md[0]; pol = 1'b1; lsb = 1'b0; dd = 3'd2; sd = 3'd0; wlen = 6'd16;
            cur_req = "R8";
            do_reset(); preamble();
            send_word(next_val(), 1'b1, 5, 0, 1'b0);
            send_word(next_val(), 1'b0, 16, 0, 1'b1);
            finish_scn("R8 only complete word");
            chk("R8 frame_err set", frame_err, 1);
            for (int i = 0; i < 4; i++) bper(hold_lvl, 1'b0);
            chk("R9 frame_err sticky", frame_err, 1);
            @(negedge clk); err_clear = 1'b1;
            @(negedge clk); err_clear = 1'b0;
            @(negedge clk);
            chk("R9 frame_err cleared", frame_err, 0);
        end

        // R8: early event during DELAY
        lr = 1'b1; pol = 1'b1; dd = 3'd4; sd = 3'd0; wlen = 6'd8;
        cur_req = "R8";
        do_reset(); preamble();
        send_word(next_val(), 1'b1, 0, 0, 1'b0);
        send_word(next_val(), 1'b0, 8, 0, 1'b1);
        finish_scn("R8 delay abort words");
        chk("R8 delay abort frame_err", frame_err, 1);

        // R11: length clamping at both ends
        lr = 1'b0; pol = 1'b1; lsb = 1'b1; dd = 3'd0; sd = 3'd0; wlen = 6'd40;
        run_std(2, "R11 long");
        wlen = 6'd3;
        run_std(2, "R11 short");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule